// File: doc/BRIEF.md
# Hybrid Network Path Selector

This block sits at the network interface of each core in a clustered many-core chip that has two fabrics: a short-reach electrical mesh and a global optical broadcast network. For every outgoing message it takes the source and destination tile coordinates and a broadcast flag. It computes the Manhattan hop distance between the two tiles and chooses the fabric that should carry the message.

A unicast message to a nearby tile stays on the mesh. A unicast message to a distant tile goes over the optical network. Every broadcast goes over the optical network. A unicast message addressed to the sending tile itself is marked local and uses neither fabric. Each tile stands for about one millimetre of mesh wire per hop.

The decision is registered behind a valid/ready handshake with one cycle of latency. It is emitted together with the hop count and the cluster that owns the destination tile. Clusters are square groups of tiles that share one optical hub. With the default parameters a 32x32 grid forms 64 clusters of 4x4 tiles.

Top module: `net_path_sel`

## Requirements
- R1: After reset is released, `out_valid_o` is low and `in_ready_o` is high.
- R2: `out_hops_o` equals |dst_x - src_x| + |dst_y - src_y|. The maximum is 62 on the default 32x32 grid.
- R3: A unicast message (`bcast_i` = 0) with a hop count from 1 to 3 is given path code 1 (electrical mesh).
- R4: A unicast message with a hop count of 4 or more is given path code 2 (optical network).
- R5: A broadcast message (`bcast_i` = 1) is given path code 2, whatever its hop count, even when source and destination are the same tile.
- R6: A unicast message whose destination equals its source is given path code 0 (local) and a hop count of 0.
- R7: `out_cluster_o` is {dst_y[4:2], dst_x[4:2]}, with the y part in bits 5:3 and the x part in bits 2:0.
- R8: A message accepted at a clock edge (`in_valid_i` and `in_ready_o` both high) appears on the outputs with `out_valid_o` high right after that edge.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the outputs hold their values, `in_ready_o` is low, and new input is not taken.
- R10: When the output is taken and no new message is accepted at the same edge, `out_valid_o` falls after that edge. `in_ready_o` is high whenever the output is empty or being taken.
- R11: Messages leave in the order they were accepted, including back-to-back transfers and release from a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be taken |
| src_x_i | input | 5 | Source tile column |
| src_y_i | input | 5 | Source tile row |
| dst_x_i | input | 5 | Destination tile column |
| dst_y_i | input | 5 | Destination tile row |
| bcast_i | input | 1 | Message is a broadcast |
| out_valid_o | output | 1 | Decision valid |
| out_ready_i | input | 1 | Consumer takes the decision |
| out_path_o | output | 2 | 0 local, 1 mesh, 2 optical |
| out_hops_o | output | 6 | Manhattan hop count |
| out_cluster_o | output | 6 | Cluster of the destination tile |

## Verification
On every cycle the assertions check the handshake: outputs hold under back-pressure, an accepted request shows up one cycle later, and the output drains when it is taken. They also tie the path code to the hop count produced by separate logic: a mesh decision always has 1 to 3 hops, and a local decision has zero hops. Other behaviours appear only in the bench's directed scenarios. These are the exact hop arithmetic, the threshold edge at four hops, a broadcast overriding a short or self-addressed route, the cluster numbering at the grid corners, and ordering across a stall release.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [1:0] {
    PATH_LOCAL = 2'd0,
    PATH_MESH  = 2'd1,
    PATH_OPTIC = 2'd2
  } path_e;
endpackage

// File: rtl/nps_hop_dist.sv
module nps_hop_dist #(
  parameter int CW = 5,
  parameter int HW = CW + 1
) (
  input  logic [CW-1:0] src_x_i,
  input  logic [CW-1:0] src_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic [HW-1:0] hops_o
);
  logic [CW-1:0] a_s [2];
  logic [CW-1:0] a_d [2];
  logic [CW-1:0] diff [2];

  assign a_s[0] = src_x_i;
  assign a_s[1] = src_y_i;
  assign a_d[0] = dst_x_i;
  assign a_d[1] = dst_y_i;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    assign diff[g] = (a_d[g] >= a_s[g]) ? (a_d[g] - a_s[g]) : (a_s[g] - a_d[g]);
  end

  assign hops_o = HW'(diff[0]) + HW'(diff[1]);
endmodule

// File: rtl/nps_path_decide.sv
module nps_path_decide #(
  parameter int HW     = 6,
  parameter int THRESH = 4
) (
  input  logic [HW-1:0]     hops_i,
  input  logic              bcast_i,
  output nps_pkg::path_e    path_o
);
  import nps_pkg::*;
  localparam logic [HW-1:0] THR = HW'(THRESH);

  always_comb begin
    if (bcast_i)                path_o = PATH_OPTIC;
    else if (hops_i == '0)      path_o = PATH_LOCAL;
    else if (hops_i < THR)      path_o = PATH_MESH;
    else                        path_o = PATH_OPTIC;
  end
endmodule

// File: rtl/nps_cluster_map.sv
module nps_cluster_map #(
  parameter int CW    = 5,
  parameter int SHIFT = 2,
  parameter int CLW   = 2 * (CW - SHIFT)
) (
  input  logic [CW-1:0]  dst_x_i,
  input  logic [CW-1:0]  dst_y_i,
  output logic [CLW-1:0] cluster_o
);
  localparam int HALF = CW - SHIFT;
  // row-major cluster index: y slice high, x slice low
  assign cluster_o = {dst_y_i[CW-1 -: HALF], dst_x_i[CW-1 -: HALF]};
endmodule

// File: rtl/nps_out_stage.sv
module nps_out_stage #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= data_i;
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(data_o)));

  p_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);
endmodule

// File: rtl/net_path_sel.sv
module net_path_sel #(
  parameter int CW     = 5,
  parameter int SHIFT  = 2,
  parameter int THRESH = 4,
  localparam int HW    = CW + 1,
  localparam int CLW   = 2 * (CW - SHIFT)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [CW-1:0]  src_x_i,
  input  logic [CW-1:0]  src_y_i,
  input  logic [CW-1:0]  dst_x_i,
  input  logic [CW-1:0]  dst_y_i,
  input  logic           bcast_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [1:0]     out_path_o,
  output logic [HW-1:0]  out_hops_o,
  output logic [CLW-1:0] out_cluster_o
);
  import nps_pkg::*;
  localparam int PW = 2 + HW + CLW;

  logic [HW-1:0]  hops;
  path_e          path;
  logic [CLW-1:0] cluster;
  logic [PW-1:0]  pay_d, pay_q;

  nps_hop_dist #(.CW(CW), .HW(HW)) u_dist (
    .src_x_i(src_x_i), .src_y_i(src_y_i),
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .hops_o(hops)
  );

  nps_path_decide #(.HW(HW), .THRESH(THRESH)) u_decide (
    .hops_i(hops), .bcast_i(bcast_i), .path_o(path)
  );

  nps_cluster_map #(.CW(CW), .SHIFT(SHIFT), .CLW(CLW)) u_cmap (
    .dst_x_i(dst_x_i), .dst_y_i(dst_y_i), .cluster_o(cluster)
  );

  assign pay_d = {path, hops, cluster};

  nps_out_stage #(.W(PW)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .data_i(pay_d),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .data_o(pay_q)
  );

  assign {out_path_o, out_hops_o, out_cluster_o} = pay_q;

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_mesh_near_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_path_o == PATH_MESH) |->
      (out_hops_o != '0 && out_hops_o < HW'(THRESH)));

  p_local_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_path_o == PATH_LOCAL) |-> (out_hops_o == '0));

  p_path_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_path_o != 2'd3));
endmodule

// File: tb/net_path_sel_tb.sv
`timescale 1ns/1ps
module net_path_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, bcast = 1'b0, out_ready = 1'b1;
  logic [4:0] sx = '0, sy = '0, dx = '0, dy = '0;
  logic in_ready, out_valid;
  logic [1:0] path;
  logic [5:0] hops, cl;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  net_path_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .src_x_i(sx), .src_y_i(sy), .dst_x_i(dx), .dst_y_i(dy), .bcast_i(bcast),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_path_o(path), .out_hops_o(hops), .out_cluster_o(cl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_hops(int a, int b, int c, int d);
    return ((c > a) ? c - a : a - c) + ((d > b) ? d - b : b - d);
  endfunction

  function automatic int e_path(int h, bit b);
    if (b) return 2;
    if (h == 0) return 0;
    if (h < 4) return 1;
    return 2;
  endfunction

  function automatic int e_cl(int x, int y);
    return ((y >> 2) << 3) | (x >> 2);
  endfunction

  task automatic drive(int a, int b, int c, int d, bit bc);
    sx = 5'(a); sy = 5'(b); dx = 5'(c); dy = 5'(d); bcast = bc; in_valid = 1'b1;
  endtask

  task automatic chk_out(int a, int b, int c, int d, bit bc, string req);
    int h;
    h = e_hops(a, b, c, d);
    chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
    chk(int'(hops) == h, {req, " hops"}, int'(hops), h);
    chk(int'(path) == e_path(h, bc), {req, " path"}, int'(path), e_path(h, bc));
    chk(int'(cl) == e_cl(c, d), {req, " cluster"}, int'(cl), e_cl(c, d));
  endtask

  // single transfer with consumer ready; R8 latency
  task automatic one(int a, int b, int c, int d, bit bc, string req);
    @(negedge clk);
    out_ready = 1'b1;
    drive(a, b, c, d, bc);
    @(negedge clk);
    chk_out(a, b, c, d, bc, req);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drain", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
  endtask

  task automatic t_local;
    one(5, 5, 5, 5, 1'b0, "R6 self");
  endtask

  task automatic t_mesh;
    one(0, 0, 1, 2, 1'b0, "R3 three hops");
    one(10, 10, 9, 10, 1'b0, "R3 one hop");
  endtask

  task automatic t_thresh;
    one(0, 0, 2, 2, 1'b0, "R4 four hops");
    one(31, 31, 0, 0, 1'b0, "R2 max hops");
    one(20, 3, 17, 9, 1'b0, "R2 mixed sign");
  endtask

  task automatic t_bcast;
    one(3, 3, 3, 3, 1'b1, "R5 self bcast");
    one(3, 3, 4, 3, 1'b1, "R5 near bcast");
  endtask

  task automatic t_cluster;
    one(0, 0, 31, 0, 1'b0, "R7 x corner");
    one(0, 0, 0, 31, 1'b0, "R7 y corner");
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 1, 2, 1, 1'b0);
    @(negedge clk);
    chk_out(1, 1, 2, 1, 1'b0, "R8 stall first");
    chk(in_ready == 1'b0, "R9 ready low", int'(in_ready), 0);
    drive(0, 0, 8, 8, 1'b0);
    repeat (2) @(negedge clk);
    chk_out(1, 1, 2, 1, 1'b0, "R9 hold");
    out_ready = 1'b1;
    #0.5;
    chk(in_ready == 1'b1, "R10 ready on take", int'(in_ready), 1);
    @(negedge clk);
    chk_out(0, 0, 8, 8, 1'b0, "R11 after release");
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 drain stall", int'(out_valid), 0);
  endtask

  task automatic t_stream;
    int q [4][4] = '{'{0, 0, 0, 1}, '{4, 4, 9, 9}, '{7, 7, 7, 7}, '{2, 9, 2, 6}};
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) chk_out(q[i-1][0], q[i-1][1], q[i-1][2], q[i-1][3], 1'b0, "R11 stream");
      if (i < 4) drive(q[i][0], q[i][1], q[i][2], q[i][3], 1'b0);
      else in_valid = 1'b0;
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R10 stream end", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local();
    t_mesh();
    t_thresh();
    t_bcast();
    t_cluster();
    t_stall();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule